// File: doc/BRIEF.md
# Backplane Clock and Frame Monitor with Interrupt Latches

This block checks a backplane bit clock (nominally 8 MHz) and its active-low frame pulse. It samples both with a much faster local clock, typically about 131 MHz, where one bus clock period is about 16 ticks. Two copies of the monitor run side by side, one for bus A and one for bus B. Each copy learns the length of the last bus clock period. It flags an error when the next rising edge comes more than `TOL` ticks earlier or later than that period predicts. It also flags an error when the frame pulse is missing where it is due, or appears where it is not due. A frame lasts `FRAME_LEN` bus clock periods.

Bus A errors, bus B errors, an external PLL error input and the bus A frame-boundary event each set their own sticky latch. Software clears a latch by writing a one to it. A mask bit per latch removes that latch from the interrupt OR but leaves it readable. The interrupt pin has a selectable asserted level and can be push-pull or open drain. When data gating is enabled, any bus error drops `data_oe`, the enable for the data outputs. `data_oe` returns only after a frame boundary has been seen and one complete frame after it has passed without error.

The per-bus state machine has states MON_HUNT, MON_MEASURE and MON_TRACK:
- HUNT goes to MEASURE on the first rise.
- MEASURE goes to TRACK on the second rise.
- TRACK stays in TRACK on each rise and compares the interval with the last one.
- TRACK goes back to HUNT on a timeout, which is also an error.

The frame tracker has states FRM_SEARCH and FRM_LOCKED:
- SEARCH goes to LOCKED on a low frame pulse.
- LOCKED goes back to SEARCH on a missing pulse or a clock timeout.
- An early pulse is an error, and the tracker re-aligns on it.

The gate has states GATE_OPEN, GATE_AWAIT_BOUND and GATE_CLEAN_RUN:
- OPEN goes to AWAIT on an error.
- AWAIT goes to CLEAN on a boundary.
- CLEAN goes to OPEN on the next boundary.
- CLEAN goes back to AWAIT on an error.
- Clearing the gate enable forces OPEN.

Top module: `busclk_monitor`

## Requirements
- R1: A rising bus clock edge whose interval since the previous rise differs by more than TOL ticks from the previous interval sets that bus's error latch. Bit 0 is bus A and bit 1 is bus B. Slow drift within TOL per period sets nothing, and one bus never sets the other bus's bit.
- R2: If no rising edge arrives within the previous interval plus TOL ticks, the bus's error latch is set and the monitor re-acquires the clock.
- R3: If the frame pulse is not low at the rising edge where a frame ends (FRAME_LEN edges after the last accepted pulse), the bus's error latch is set.
- R4: A frame pulse low at any other rising edge sets the bus's error latch.
- R5: A bus A frame pulse accepted on a clean edge sets latch bit 3 (frame boundary), which is not an error.
- R6: Latches are read at address 0 and stay set until a write to address 0 with a one in their bit position. If a new event arrives in the same cycle as the clear, the latch stays set.
- R7: The mask register at address 1 resets to all ones. A masked latch does not drive the interrupt but still reads back at address 0.
- R8: The interrupt is active when any latch is set while its mask bit is 0. Control bit 0 (address 2) selects the asserted level: 1 means high, 0 means low.
- R9: With control bit 1 set (open drain), `irq_oe` is high only while the interrupt is active, and `irq_o` then carries the asserted level.
- R10: With control bit 2 set, a bus error drops `data_oe`. `data_oe` returns only after a frame boundary followed by one full frame without errors. With bit 2 clear, `data_oe` stays high.
- R11: A high `pll_err` sets latch bit 2.
- R12: After reset: latches 0, mask 0xF, control 0, `data_oe` high, `irq_oe` high and `irq_o` high (deasserted, active-low level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst | input | 1 | Synchronous reset, active high |
| bclk_a | input | 1 | Bus A bit clock |
| frame_a_n | input | 1 | Bus A frame pulse, active low |
| bclk_b | input | 1 | Bus B bit clock |
| frame_b_n | input | 1 | Bus B frame pulse, active low |
| pll_err | input | 1 | External PLL error event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 latches, 1 mask, 2 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin drive enable |
| data_oe | output | 1 | Data output enable |

## Verification
The bench builds the block with FRAME_LEN = 8, TOL = 4 and CNT_W = 6. A frame is then about 128 sample ticks, so missed pulses, extra pulses, re-lock and the full-clean-frame release of the data gate all fit in short runs. Bus A runs with random period drift of up to two ticks per period, which must never trip the window. Directed shortened periods, stalled clocks, skipped pulses and extra pulses must each trip it.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
    typedef enum logic [1:0] {MON_HUNT, MON_MEASURE, MON_TRACK} mon_state_t;
    typedef enum logic {FRM_SEARCH, FRM_LOCKED} frm_state_t;
    typedef enum logic [1:0] {GATE_OPEN, GATE_AWAIT_BOUND, GATE_CLEAN_RUN} gate_state_t;

    localparam int NSRC      = 4;
    localparam int SRC_ERR_A = 0;
    localparam int SRC_ERR_B = 1;
    localparam int SRC_PLL   = 2;
    localparam int SRC_FRAME = 3;

    localparam logic [1:0] ADDR_LATCH = 2'd0;
    localparam logic [1:0] ADDR_MASK  = 2'd1;
    localparam logic [1:0] ADDR_CTRL  = 2'd2;

    localparam int CTRL_W    = 3;
    localparam int CTRL_POL  = 0;
    localparam int CTRL_OD   = 1;
    localparam int CTRL_GATE = 2;
endpackage

// File: rtl/bcm_bus_mon.sv
module bcm_bus_mon
    import bcm_pkg::*;
#(
    parameter int CNT_W       = 6,
    parameter int TOL         = 4,
    parameter int FRAME_LEN   = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk_in,
    input  logic frame_n_in,
    output logic err_o,
    output logic bound_o
);
    localparam int SLOT_W = $clog2(FRAME_LEN);
    localparam int EXT_W  = CNT_W + 1;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_LEN - 1);
    localparam logic [EXT_W-1:0]  TOL_X     = EXT_W'(TOL);

    logic [SYNC_STAGES-1:0] clk_sync, frm_sync;
    logic                   clk_prev;
    mon_state_t             mon_q, mon_d;
    frm_state_t             frm_q, frm_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d, per_q, per_d;
    logic [SLOT_W-1:0]      slot_q, slot_d;
    logic                   err_q, err_d, bnd_q, bnd_d;
    logic                   rise, frame_low, timeout, edge_err, frm_err;
    logic [EXT_W-1:0]       interval, per_x;

    assign rise      = clk_sync[SYNC_STAGES-1] & ~clk_prev;
    assign frame_low = ~frm_sync[SYNC_STAGES-1];
    assign interval  = {1'b0, cnt_q} + EXT_W'(1);
    assign per_x     = {1'b0, per_q};
    assign timeout   = (mon_q == MON_TRACK) && !rise && (interval == per_x + TOL_X + EXT_W'(1));

    // next state
    always_comb begin
        mon_d    = mon_q;
        frm_d    = frm_q;
        per_d    = per_q;
        slot_d   = slot_q;
        cnt_d    = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
        edge_err = 1'b0;
        frm_err  = 1'b0;
        bnd_d    = 1'b0;
        unique case (mon_q)
            MON_HUNT: if (rise) begin
                mon_d = MON_MEASURE;
                cnt_d = '0;
            end
            MON_MEASURE: if (rise) begin
                mon_d = MON_TRACK;
                per_d = interval[CNT_W] ? '1 : interval[CNT_W-1:0];
                cnt_d = '0;
            end
            MON_TRACK: if (rise) begin
                per_d    = interval[CNT_W] ? '1 : interval[CNT_W-1:0];
                cnt_d    = '0;
                edge_err = ((interval + TOL_X) < per_x) || (interval > per_x + TOL_X);
            end else if (timeout) begin
                edge_err = 1'b1;
                mon_d    = MON_HUNT;
            end
            default: mon_d = MON_HUNT;
        endcase
        if (timeout) begin
            frm_d = FRM_SEARCH;
        end else if (rise) begin
            unique case (frm_q)
                FRM_SEARCH: if (frame_low) begin
                    frm_d  = FRM_LOCKED;
                    slot_d = '0;
                    bnd_d  = !edge_err;
                end
                FRM_LOCKED: if (slot_q == LAST_SLOT) begin
                    if (frame_low) begin
                        slot_d = '0;
                        bnd_d  = !edge_err;
                    end else begin
                        frm_err = 1'b1;
                        frm_d   = FRM_SEARCH;
                    end
                end else if (frame_low) begin
                    frm_err = 1'b1;
                    slot_d  = '0;
                end else begin
                    slot_d = slot_q + 1'b1;
                end
                default: frm_d = FRM_SEARCH;
            endcase
        end
        err_d = edge_err | frm_err;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sync <= '0;
            frm_sync <= '1;
            clk_prev <= 1'b0;
            mon_q    <= MON_HUNT;
            frm_q    <= FRM_SEARCH;
            cnt_q    <= '0;
            per_q    <= '0;
            slot_q   <= '0;
            err_q    <= 1'b0;
            bnd_q    <= 1'b0;
        end else begin
            clk_sync <= {clk_sync[SYNC_STAGES-2:0], bclk_in};
            frm_sync <= {frm_sync[SYNC_STAGES-2:0], frame_n_in};
            clk_prev <= clk_sync[SYNC_STAGES-1];
            mon_q    <= mon_d;
            frm_q    <= frm_d;
            cnt_q    <= cnt_d;
            per_q    <= per_d;
            slot_q   <= slot_d;
            err_q    <= err_d;
            bnd_q    <= bnd_d;
        end
    end

    assign err_o   = err_q;
    assign bound_o = bnd_q;

    // R5: a boundary is never reported together with an error
    a_r5_bound_clean: assert property (@(posedge clk) disable iff (rst) !(err_q && bnd_q));
    // R2: a timeout always forces re-acquisition of the clock
    a_r2_timeout_rehunt: assert property (@(posedge clk) disable iff (rst)
        (mon_q == MON_TRACK && !rise && interval == per_x + TOL_X + EXT_W'(1)) |=> (mon_q == MON_HUNT && err_q));
endmodule

// File: rtl/bcm_irq_regs.sv
module bcm_irq_regs
    import bcm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   events,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              gate_en,
    output logic              irq_o,
    output logic              irq_oe
);
    logic [NSRC-1:0]   lat_q, mask_q, clr;
    logic [CTRL_W-1:0] ctrl_q;
    logic              active, pol;

    assign clr = (reg_wr && reg_addr == ADDR_LATCH) ? reg_wdata[NSRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q  <= '0;
            mask_q <= '1;
            ctrl_q <= '0;
        end else begin
            lat_q <= (lat_q & ~clr) | events;
            if (reg_wr && reg_addr == ADDR_MASK) mask_q <= reg_wdata[NSRC-1:0];
            if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
        end
    end

    always_comb begin
        active  = |(lat_q & ~mask_q);
        pol     = ctrl_q[CTRL_POL];
        gate_en = ctrl_q[CTRL_GATE];
        if (ctrl_q[CTRL_OD]) begin
            irq_oe = active;
            irq_o  = pol;
        end else begin
            irq_oe = 1'b1;
            irq_o  = active ? pol : ~pol;
        end
        case (reg_addr)
            ADDR_LATCH: reg_rdata = DATA_W'(lat_q);
            ADDR_MASK:  reg_rdata = DATA_W'(mask_q);
            ADDR_CTRL:  reg_rdata = DATA_W'(ctrl_q);
            default:    reg_rdata = '0;
        endcase
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        // R6: an event always leaves its latch set, even against a clear
        a_r6_event_sets: assert property (@(posedge clk) disable iff (rst) events[i] |=> lat_q[i]);
        // R6: without a clear a set latch holds
        a_r6_latch_holds: assert property (@(posedge clk) disable iff (rst) (lat_q[i] && !clr[i]) |=> lat_q[i]);
    end
endmodule

// File: rtl/bcm_data_gate.sv
module bcm_data_gate
    import bcm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic gate_en,
    input  logic bus_err,
    input  logic bound,
    output logic data_oe
);
    gate_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!gate_en) begin
            st_d = GATE_OPEN;
        end else begin
            unique case (st_q)
                GATE_OPEN:        if (bus_err) st_d = GATE_AWAIT_BOUND;
                GATE_AWAIT_BOUND: if (!bus_err && bound) st_d = GATE_CLEAN_RUN;
                GATE_CLEAN_RUN:   if (bus_err) st_d = GATE_AWAIT_BOUND;
                                  else if (bound) st_d = GATE_OPEN;
                default:          st_d = GATE_AWAIT_BOUND;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= GATE_OPEN;
        else     st_q <= st_d;
    end

    always_comb data_oe = (st_q == GATE_OPEN);

    // R10: an error with gating on blanks the outputs
    a_r10_err_blanks: assert property (@(posedge clk) disable iff (rst) (gate_en && bus_err) |=> !data_oe);
    // R10: gating off keeps the outputs enabled
    a_r10_off_open: assert property (@(posedge clk) disable iff (rst) !gate_en |=> data_oe);
    // R10: with gating on, release happens only on a frame boundary
    a_r10_release_on_bound: assert property (@(posedge clk) disable iff (rst)
        ($rose(data_oe) && $past(gate_en)) |-> $past(bound));
endmodule

// File: rtl/busclk_monitor.sv
module busclk_monitor
    import bcm_pkg::*;
#(
    parameter int CNT_W       = 6,
    parameter int TOL         = 4,
    parameter int FRAME_LEN   = 1024,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk_a,
    input  logic              frame_a_n,
    input  logic              bclk_b,
    input  logic              frame_b_n,
    input  logic              pll_err,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              irq_oe,
    output logic              data_oe
);
    localparam int NBUS = 2;

    logic [NBUS-1:0] bclk_v, frame_v, bus_err, bus_bnd;
    logic [NSRC-1:0] events;
    logic            gate_en;

    assign bclk_v  = {bclk_b, bclk_a};
    assign frame_v = {frame_b_n, frame_a_n};

    for (genvar b = 0; b < NBUS; b++) begin : g_bus
        bcm_bus_mon #(
            .CNT_W(CNT_W), .TOL(TOL), .FRAME_LEN(FRAME_LEN), .SYNC_STAGES(SYNC_STAGES)
        ) u_mon (
            .clk(clk), .rst(rst), .bclk_in(bclk_v[b]), .frame_n_in(frame_v[b]),
            .err_o(bus_err[b]), .bound_o(bus_bnd[b])
        );
    end

    always_comb begin
        events            = '0;
        events[SRC_ERR_A] = bus_err[0];
        events[SRC_ERR_B] = bus_err[1];
        events[SRC_PLL]   = pll_err;
        events[SRC_FRAME] = bus_bnd[0];
    end

    bcm_irq_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .events(events), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gate_en(gate_en),
        .irq_o(irq_o), .irq_oe(irq_oe)
    );

    bcm_data_gate u_gate (
        .clk(clk), .rst(rst), .gate_en(gate_en), .bus_err(|bus_err),
        .bound(bus_bnd[0]), .data_oe(data_oe)
    );
endmodule

// File: tb/tb_busclk_monitor.sv
module tb_busclk_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int FL = 8;
    localparam int FR = FL * 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bclk = 2'b00;
    logic [1:0] frn = 2'b11;
    logic       pll_err = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq_o, irq_oe, data_oe;

    int  checks = 0, fails = 0;
    int  per_nom[2] = '{16, 16};
    int  delta_req[2] = '{0, 0};
    bit  skip_req[2] = '{0, 0};
    bit  extra_req[2] = '{0, 0};
    bit  rand_on[2] = '{1, 0};

    always #(CLK_PERIOD/2) clk = ~clk;

    busclk_monitor #(.CNT_W(6), .TOL(4), .FRAME_LEN(FL), .SYNC_STAGES(2), .DATA_W(8)) dut (
        .clk(clk), .rst(rst), .bclk_a(bclk[0]), .frame_a_n(frn[0]), .bclk_b(bclk[1]),
        .frame_b_n(frn[1]), .pll_err(pll_err), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .irq_oe(irq_oe),
        .data_oe(data_oe)
    );

    function automatic logic [1:0] exp_irq(logic [3:0] lat, logic [3:0] mask, logic [2:0] ctrl);
        logic act = |(lat & ~mask);
        if (ctrl[1]) return {act, ctrl[0]};
        return {1'b1, act ? ctrl[0] : ~ctrl[0]};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
        reg_addr = 2'd0;
    endtask

    task automatic run_bus(input int b);
        int k = 0;
        forever begin
            int p = per_nom[b];
            bit pulse;
            if (rand_on[b]) begin
                p = p + int'($urandom % 5) - 2;
                if (p < 12) p = 12;
                if (p > 20) p = 20;
                per_nom[b] = p;
            end
            if (delta_req[b] != 0) begin
                p = p + delta_req[b];
                delta_req[b] = 0;
            end
            bclk[b] = 1'b1;
            ticks(p / 2);
            k++;
            pulse = (k % FL) == 0;
            if (pulse && skip_req[b]) begin
                pulse = 1'b0; skip_req[b] = 1'b0;
            end else if (!pulse && extra_req[b]) begin
                pulse = 1'b1; extra_req[b] = 1'b0;
            end
            bclk[b] = 1'b0;
            frn[b] = !pulse;
            ticks(p - p / 2);
        end
    endtask

    task automatic recover();
        logic [7:0] v;
        ticks(4 * FR);
        wr(2'd0, 8'h0F);
        ticks(2 * FR);
        rd(2'd0, v);
        chk("R1", "no bus error after re-lock", int'(v[1:0]), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [1:0] e;
        void'($urandom(32'd7741));
        ticks(5);
        // R12 reset state
        rd(2'd0, v); chk("R12", "latches", int'(v), 0);
        rd(2'd1, v); chk("R12", "mask", int'(v), 15);
        rd(2'd2, v); chk("R12", "ctrl", int'(v), 0);
        chk("R12", "data_oe", int'(data_oe), 1);
        chk("R12", "irq_oe", int'(irq_oe), 1);
        chk("R12", "irq_o", int'(irq_o), 1);
        rst = 1'b0;
        fork
            run_bus(0);
            run_bus(1);
        join_none

        // R1/R5 random drift, no errors; boundaries latched
        ticks(4 * FR);
        wr(2'd0, 8'h0F);
        ticks(3 * FR);
        rd(2'd0, v);
        chk("R1", "drift no error", int'(v[1:0]), 0);
        chk("R5", "frame boundary bit3", int'(v[3]), 1);
        chk("R7", "masked boundary keeps irq off", int'(irq_o), 1);

        // R1 early edge on A
        delta_req[0] = -8;
        wait (delta_req[0] == 0);
        ticks(60);
        rd(2'd0, v);
        chk("R1", "early edge bit0", int'(v[0]), 1);
        chk("R1", "bus B untouched", int'(v[1]), 0);
        recover();

        // R2 stalled clock
        delta_req[0] = 100;
        wait (delta_req[0] == 0);
        ticks(60);
        rd(2'd0, v);
        chk("R2", "timeout bit0", int'(v[0]), 1);
        recover();

        // R3 missing frame pulse
        skip_req[0] = 1'b1;
        wait (skip_req[0] == 1'b0);
        ticks(40);
        rd(2'd0, v);
        chk("R3", "missing pulse bit0", int'(v[0]), 1);
        recover();

        // R4 extra frame pulse
        extra_req[0] = 1'b1;
        wait (extra_req[0] == 1'b0);
        ticks(40);
        rd(2'd0, v);
        chk("R4", "unexpected pulse bit0", int'(v[0]), 1);
        recover();

        // R1 bus B early edge
        delta_req[1] = -8;
        wait (delta_req[1] == 0);
        ticks(60);
        rd(2'd0, v);
        chk("R1", "bus B bit1", int'(v[1]), 1);
        chk("R1", "bus A untouched", int'(v[0]), 0);
        recover();

        // R11 PLL error, R6 hold / clear / collision
        @(negedge clk); pll_err = 1'b1;
        @(negedge clk); pll_err = 1'b0;
        ticks(2);
        rd(2'd0, v); chk("R11", "pll bit2", int'(v[2]), 1);
        ticks(50);
        rd(2'd0, v); chk("R6", "latch holds", int'(v[2]), 1);
        wr(2'd0, 8'h04);
        rd(2'd0, v); chk("R6", "clear bit2", int'(v[2]), 0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h04; pll_err = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; pll_err = 1'b0;
        rd(2'd0, v); chk("R6", "event beats clear", int'(v[2]), 1);

        // R8 / R9 interrupt pin
        wr(2'd1, 8'h0B);
        e = exp_irq(4'b0100, 4'hB, 3'd0);
        chk("R8", "active-low asserted", int'(irq_o), int'(e[0]));
        wr(2'd2, 8'h01);
        e = exp_irq(4'b0100, 4'hB, 3'd1);
        chk("R8", "active-high asserted", int'(irq_o), int'(e[0]));
        wr(2'd2, 8'h03);
        e = exp_irq(4'b0100, 4'hB, 3'd3);
        chk("R9", "open drain oe active", int'(irq_oe), int'(e[1]));
        chk("R9", "open drain level", int'(irq_o), int'(e[0]));
        wr(2'd0, 8'h04);
        e = exp_irq(4'b0000, 4'hB, 3'd3);
        chk("R9", "open drain released", int'(irq_oe), int'(e[1]));
        wr(2'd2, 8'h02);
        @(negedge clk); pll_err = 1'b1;
        @(negedge clk); pll_err = 1'b0;
        ticks(1);
        e = exp_irq(4'b0100, 4'hB, 3'd2);
        chk("R9", "open drain low oe", int'(irq_oe), int'(e[1]));
        chk("R9", "open drain low level", int'(irq_o), int'(e[0]));
        wr(2'd1, 8'h0F);
        e = exp_irq(4'b0100, 4'hF, 3'd2);
        chk("R7", "remasked oe", int'(irq_oe), int'(e[1]));
        rd(2'd0, v); chk("R7", "masked latch readable", int'(v[2]), 1);
        wr(2'd2, 8'h00);

        // R10 data gating
        wr(2'd2, 8'h04);
        ticks(2 * FR);
        chk("R10", "open before error", int'(data_oe), 1);
        delta_req[0] = -8;
        wait (delta_req[0] == 0);
        ticks(20);
        chk("R10", "blanked after error", int'(data_oe), 0);
        ticks(80);
        chk("R10", "still blanked before clean frame", int'(data_oe), 0);
        ticks(4 * FR);
        chk("R10", "reopened after clean frame", int'(data_oe), 1);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h0F);
        delta_req[0] = -8;
        wait (delta_req[0] == 0);
        ticks(20);
        chk("R10", "gating off stays open", int'(data_oe), 1);
        rd(2'd0, v); chk("R1", "error seen with gating off", int'(v[0]), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule